// File: doc/BRIEF.md
# Mode-Configurable SPI Master

This block is a single-channel SPI master for exactly one slave, moving one byte per transfer. The host holds the byte to send on `tx_byte_i` and pulses `start_i` for one cycle. The block then pulls the active-low select line low and produces eight serial clock periods from the system clock. It shifts the byte out on MOSI and, on the same edges the slave uses, samples MISO. When the transfer ends it releases the select line and presents the received byte together with a one-cycle `done_o` pulse.

Four build-time parameters fix the wire timing. `CPOL` sets the resting level of the serial clock. `CPHA` chooses whether data is sampled on the leading or the trailing edge of each clock period. `LSB_FIRST` picks which end of the byte goes on the wire first. `DIV` sets the length of each half-period of the serial clock in system clocks. With these, one RTL module can serve any of the four SPI timing modes:

| Mode | CPOL | CPHA | Sample edge |
|---|---|---|---|
| 0 | 0 | 0 | rising |
| 1 | 0 | 1 | falling |
| 2 | 1 | 0 | falling |
| 3 | 1 | 1 | rising |

Top module: `spi_mode_master`

## Requirements
- R1: After reset, and whenever select is high, `sclk_o` sits at the `CPOL` level (0 when CPOL=0, 1 when CPOL=1).
- R2: After reset `ss_n_o` is 1 and `busy_o` is 0. `ss_n_o` stays 0 and `busy_o` stays 1 for the whole transfer.
- R3: Each transfer has exactly 16 `sclk_o` transitions, spaced `DIV` system clocks apart. The first transition comes `DIV` clocks after `ss_n_o` falls, and `ss_n_o` rises `DIV` clocks after the last transition.
- R4: With CPHA=0, the first data bit is on `mosi_o` from the cycle in which `ss_n_o` falls. Bits are sampled on leading edges (the transitions away from the CPOL level). `mosi_o` changes only on trailing edges.
- R5: With CPHA=1, each bit is driven onto `mosi_o` at a leading edge and sampled at the following trailing edge.
- R6: `miso_i` is captured on the same edges on which the slave samples `mosi_o`, so `rx_byte_o` equals the byte the slave sent.
- R7: With LSB_FIRST=0, bit 7 goes on the wire first. With LSB_FIRST=1, bit 0 goes first. The received byte is rebuilt in the same order. For example, 0xB5 sent LSB-first, read in wire order with the first bit as the most significant, gives 0xAD.
- R8: `done_o` is high for exactly one system clock, in the cycle in which `ss_n_o` has returned to 1, and `rx_byte_o` is valid in that cycle.
- R9: A `start_i` pulse that arrives while `busy_o` is 1 is ignored. The running transfer keeps its data, and no extra transfer or `done_o` pulse follows.
- R10: A `start_i` pulse while idle is accepted on that clock edge, so `busy_o` is 1 and `ss_n_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tx_byte_i | input | 8 | Byte to send, captured when the start is accepted |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse: `rx_byte_o` holds a new byte |
| rx_byte_o | output | 8 | Last byte received |
| sclk_o | output | 1 | Serial clock to the slave |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data to the slave |

## Verification
The assertions assume that `start_i` is a clean synchronous pulse. They also assume that the slave changes `miso_i` only on its own drive edges, never in the cycle in which the master samples it. The bench drives every input on the falling system clock edge. Its behavioural slave reacts only to select and serial-clock transitions, so `miso_i` is always settled a full half-period before it is sampled. The bench issues repeated starts only after `busy_o` has dropped, except for the deliberate mid-transfer pulses that test R9.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int EDGES  = 2 * BYTE_W;

  // Bit placed on the wire from a transmit shift register.
  function automatic logic wire_bit(input logic [BYTE_W-1:0] sh, input bit lsb);
    return lsb ? sh[0] : sh[BYTE_W-1];
  endfunction

  // Transmit register after one bit has left.
  function automatic logic [BYTE_W-1:0] tx_advance(input logic [BYTE_W-1:0] sh, input bit lsb);
    return lsb ? {1'b0, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], 1'b0};
  endfunction

  // Receive register after one bit has arrived.
  function automatic logic [BYTE_W-1:0] rx_insert(input logic [BYTE_W-1:0] sh, input logic b,
                                                  input bit lsb);
    return lsb ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_seq.sv
module spim_seq import spim_pkg::*; #(
  parameter bit CPOL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic run,
  output logic accept,
  output logic edge_fire,
  output logic edge_odd,
  output logic finish,
  output logic sclk,
  output logic ss_n,
  output logic done
);
  localparam int EW = $clog2(EDGES + 1);

  logic [EW-1:0] eidx;
  logic          last_pass;

  assign last_pass = (eidx == EW'(EDGES));
  assign accept    = start && !run;
  assign edge_fire = run && tick && !last_pass;
  assign finish    = run && tick && last_pass;
  assign edge_odd  = eidx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      sclk <= CPOL;
      ss_n <= 1'b1;
      done <= 1'b0;
      eidx <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        run  <= 1'b1;
        ss_n <= 1'b0;
        eidx <= '0;
      end else if (finish) begin
        run  <= 1'b0;
        ss_n <= 1'b1;
      end else if (edge_fire) begin
        sclk <= ~sclk;
        eidx <= eidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift import spim_pkg::*; #(
  parameter bit CPHA      = 1'b0,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              edge_fire,
  input  logic              edge_odd,
  input  logic              finish,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sample_ev,
  output logic              drive_ev
);
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;

  // Even edge index = leading edge. CPHA picks which parity samples.
  assign sample_ev = edge_fire && (edge_odd == CPHA);
  assign drive_ev  = edge_fire && (edge_odd != CPHA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      mosi    <= 1'b0;
    end else begin
      if (accept) begin
        rx_sh <= '0;
        if (!CPHA) begin
          mosi  <= wire_bit(tx_byte, LSB_FIRST);
          tx_sh <= tx_advance(tx_byte, LSB_FIRST);
        end else begin
          tx_sh <= tx_byte;
        end
      end else if (drive_ev) begin
        mosi  <= wire_bit(tx_sh, LSB_FIRST);
        tx_sh <= tx_advance(tx_sh, LSB_FIRST);
      end
      if (sample_ev) rx_sh <= rx_insert(rx_sh, miso, LSB_FIRST);
      if (finish)    rx_byte <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master import spim_pkg::*; #(
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0,
  parameter bit LSB_FIRST = 1'b0,
  parameter int DIV       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sclk_o,
  output logic              ss_n_o,
  output logic              mosi_o
);
  // Named internal events, also used by the bound checker.
  logic run, tick, accept, edge_fire, edge_odd, finish;
  logic sample_ev, drive_ev;

  spim_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .run (run),
    .tick (tick)
  );

  spim_seq #(.CPOL(CPOL)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .start (start_i),
    .tick (tick),
    .run (run),
    .accept (accept),
    .edge_fire (edge_fire),
    .edge_odd (edge_odd),
    .finish (finish),
    .sclk (sclk_o),
    .ss_n (ss_n_o),
    .done (done_o)
  );

  spim_shift #(.CPHA(CPHA), .LSB_FIRST(LSB_FIRST)) u_shift (
    .clk (clk),
    .rst_n (rst_n),
    .accept (accept),
    .edge_fire (edge_fire),
    .edge_odd (edge_odd),
    .finish (finish),
    .tx_byte (tx_byte_i),
    .miso (miso_i),
    .mosi (mosi_o),
    .rx_byte (rx_byte_o),
    .sample_ev (sample_ev),
    .drive_ev (drive_ev)
  );

  assign busy_o = run;
endmodule

// File: rtl/spim_checker.sv
module spim_checker import spim_pkg::*; #(
  parameter bit CPOL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic ss_n_o,
  input logic mosi_o,
  input logic sample_ev
);
  logic       sclk_d;
  logic [5:0] ecnt;

  // Counts serial clock transitions since the last accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= CPOL;
      ecnt   <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (start_i && !busy_o)  ecnt <= '0;
      else if (sclk_o != sclk_d) ecnt <= ecnt + 1'b1;
    end
  end

  p_idle_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> (sclk_o == CPOL));

  p_select_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ss_n_o);

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ecnt == 6'(EDGES)));

  p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> $stable(mosi_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ss_n_o && !busy_o));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !ss_n_o));
endmodule

bind spi_mode_master spim_checker #(.CPOL(CPOL)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .start_i (start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .sclk_o (sclk_o),
  .ss_n_o (ss_n_o),
  .mosi_o (mosi_o),
  .sample_ev (sample_ev)
);

// File: tb/spim_lane.sv
module spim_lane #(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter bit LSB  = 1'b0,
  parameter int DIV  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   checks,
  output int   bads
);
  logic       start, busy, done, sclk, ss_n, mosi, miso;
  logic [7:0] txb, rxb;

  spi_mode_master #(.CPOL(CPOL), .CPHA(CPHA), .LSB_FIRST(LSB), .DIV(DIV)) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start), .tx_byte_i (txb), .miso_i (miso),
    .busy_o (busy), .done_o (done), .rx_byte_o (rxb), .sclk_o (sclk), .ss_n_o (ss_n),
    .mosi_o (mosi)
  );

  // ---------------- behavioural slave ----------------
  logic [7:0] s_tx = 8'h00;
  logic [7:0] s_rx = 8'h00;
  logic [7:0] s_wire = 8'h00;
  int s_dn = 0, s_sn = 0, s_edges = 0;
  logic ss_seen = 1'b1, sk_seen = CPOL;

  function automatic int bpos(input int n);
    return LSB ? n : 7 - n;
  endfunction

  initial miso = 1'b0;

  always @(ss_n or sclk) begin
    if (ss_n !== ss_seen) begin
      ss_seen = ss_n;
      if (ss_n === 1'b0) begin
        s_dn = 0; s_sn = 0; s_edges = 0; s_rx = 8'h00; s_wire = 8'h00;
        if (!CPHA) begin miso = s_tx[bpos(0)]; s_dn = 1; end
      end
    end
    if (sclk !== sk_seen) begin
      sk_seen = sclk;
      if (ss_n === 1'b0) begin
        s_edges++;
        if ((sclk != CPOL) == !CPHA) begin
          if (s_sn < 8) begin
            s_rx[bpos(s_sn)] = mosi;
            s_wire = {s_wire[6:0], mosi};
            s_sn++;
          end
        end else if (s_dn < 8) begin
          miso = s_tx[bpos(s_dn)];
          s_dn++;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];
  int d_chk = 0, d_bad = 0, m_chk = 0, m_bad = 0, m_dones = 0, pushed = 0;

  assign checks = d_chk + m_chk;
  assign bads   = d_bad + m_bad;

  function automatic logic [7:0] wire_order(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7 - i];
    return LSB ? r : b;
  endfunction

  task automatic dchk(input bit ok, input string req, input int act, input int exp);
    d_chk++;
    if (!ok) begin
      d_bad++;
      $display("FAIL %s mode=%0d%0d lsb=%0d act=%0h exp=%0h", req, CPOL, CPHA, LSB, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input int act, input int exp);
    m_chk++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s mode=%0d%0d lsb=%0d act=%0h exp=%0h", req, CPOL, CPHA, LSB, act, exp);
    end
  endtask

  // Monitor: timing gaps, done pulse width, and result comparison.
  logic ss_p = 1'b1, sk_p = CPOL, first = 1'b0, want_low = 1'b0;
  int since_ss = 0, since_edge = 0, lead_gap = 0, tail_gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_ss++; since_edge++;
      if (want_low) begin
        mchk(done == 1'b0, "R8", done, 0);
        want_low = 1'b0;
      end
      if (ss_p && !ss_n) begin since_ss = 0; first = 1'b1; end
      if (!ss_p && ss_n) tail_gap = since_edge;
      if (sclk != sk_p) begin
        if (first) begin lead_gap = since_ss; first = 1'b0; end
        since_edge = 0;
      end
      ss_p = ss_n; sk_p = sclk;
      if (done) begin
        m_dones++;
        want_low = 1'b1;
        if (exp_q.size() == 0) mchk(1'b0, "R9", m_dones, pushed);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          mchk(rxb == e[7:0], "R6", rxb, e[7:0]);
          if (CPHA) mchk(s_rx == e[15:8], "R5", s_rx, e[15:8]);
          else      mchk(s_rx == e[15:8], "R4", s_rx, e[15:8]);
          mchk(s_wire == wire_order(e[15:8]), "R7", s_wire, wire_order(e[15:8]));
          mchk(s_edges == 16, "R3", s_edges, 16);
          mchk(lead_gap == DIV, "R3", lead_gap, DIV);
          mchk(tail_gap == DIV, "R3", tail_gap, DIV);
          mchk(sclk == CPOL, "R1", sclk, CPOL);
          mchk(ss_n == 1'b1, "R8", ss_n, 1);
        end
      end
    end
  end

  // Driver
  task automatic xfer(input logic [7:0] t, input logic [7:0] s, input bit poke);
    while (busy) @(negedge clk);
    s_tx = s;
    txb = t;
    start = 1'b1;
    exp_q.push_back({t, s});
    pushed++;
    @(negedge clk);
    start = 1'b0;
    dchk(busy && !ss_n, "R10", {busy, ss_n}, 2'b10);
    if (!CPHA) dchk(mosi == t[LSB ? 0 : 7], "R4", mosi, t[LSB ? 0 : 7]);
    if (poke) begin
      repeat (2) @(negedge clk);
      txb = ~t;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      txb = t;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fin = 1'b0;
    start = 1'b0;
    txb = 8'h00;
    wait (rst_n === 1'b1);
    @(negedge clk);
    dchk(sclk == CPOL, "R1", sclk, CPOL);
    dchk(ss_n == 1'b1 && busy == 1'b0, "R2", {ss_n, busy}, 2'b10);
    dchk(done == 1'b0, "R8", done, 0);
    xfer(8'hA5, 8'h3C, 1'b0);
    xfer(8'hB5, 8'h00, 1'b1);
    xfer(8'h00, 8'hFF, 1'b0);
    xfer(8'hFF, 8'h5A, 1'b1);
    xfer(8'hB5, 8'hC3, 1'b0);
    xfer(8'h6E, 8'h91, 1'b0);
    repeat (4) @(negedge clk);
    dchk(m_dones == pushed, "R9", m_dones, pushed);
    dchk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    dchk(ss_n == 1'b1 && sclk == CPOL, "R2", {ss_n, sclk}, {1'b1, CPOL});
    fin = 1'b1;
  end
endmodule

// File: tb/sim_spi_mode_master.sv
module sim_spi_mode_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0] fin;
  int c0, c1, c2, c3, b0, b1, b2, b3;

  spim_lane #(.CPOL(1'b0), .CPHA(1'b0), .LSB(1'b0), .DIV(1)) lane0 (
    .clk (clk), .rst_n (rst_n), .fin (fin[0]), .checks (c0), .bads (b0));
  spim_lane #(.CPOL(1'b0), .CPHA(1'b1), .LSB(1'b0), .DIV(2)) lane1 (
    .clk (clk), .rst_n (rst_n), .fin (fin[1]), .checks (c1), .bads (b1));
  spim_lane #(.CPOL(1'b1), .CPHA(1'b0), .LSB(1'b1), .DIV(3)) lane2 (
    .clk (clk), .rst_n (rst_n), .fin (fin[2]), .checks (c2), .bads (b2));
  spim_lane #(.CPOL(1'b1), .CPHA(1'b1), .LSB(1'b1), .DIV(4)) lane3 (
    .clk (clk), .rst_n (rst_n), .fin (fin[3]), .checks (c3), .bads (b3));

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc = 0;
    int total;
    int bad;
    while (fin !== 4'hF && cyc < WATCHDOG) begin
      @(negedge clk);
      cyc++;
    end
    total = c0 + c1 + c2 + c3;
    bad   = b0 + b1 + b2 + b3;
    if (fin !== 4'hF) begin
      total++;
      bad++;
      $display("FAIL watchdog lanes_done=%b expected=1111", fin);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule